// File: doc/BRIEF.md
# Multiply/Divide Unit with HI/LO Result Registers

This block does the integer multiply and divide work beside a processor's main datapath. A single start strobe launches one of four arithmetic operations on two register operands: signed or unsigned multiply, and signed or unsigned divide. The results go into a pair of result registers, HI and LO, which the rest of the core reads as plain outputs. Two more operations load one of the two registers directly from the first operand. This lets the contents be restored after a context switch.

A multiply finishes in the cycle after it is accepted. It puts the upper half of the double-width product in HI and the lower half in LO. A divide runs on a restoring shift-subtract engine that produces one quotient bit per clock. One final cycle then applies the signs. When the divide completes, LO holds the quotient and HI holds the remainder. While a divide is in flight the busy flag stays high, and every start request is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 (signed multiply) treats both operands as two's-complement. In the cycle after acceptance, HI holds bits 63..32 and LO holds bits 31..0 of the exact 64-bit product.
- R2: Operation code 1 (unsigned multiply) treats both operands as unsigned and writes the full 64-bit product the same way. For example, 10 times 32'h10000000 leaves LO = 32'hA0000000 and HI = 0, and no overflow indication exists.
- R3: Operation code 2 (signed divide) leaves the quotient, truncated toward zero, in LO. It leaves the remainder in HI, with the remainder taking the sign of the dividend.
- R4: Operation code 3 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI. The remainder is smaller than the nonzero divisor.
- R5: A divide accepted on a clock edge raises busy_o for exactly WIDTH+1 cycles (WIDTH iterations plus one sign fix-up). HI and LO are written on the edge where busy_o falls.
- R6: HI and LO do not change while busy_o is high.
- R7: A start request of any operation code while busy_o is high is ignored.
- R8: Operation code 4 copies a_i into HI and operation code 5 copies a_i into LO. Each leaves the other register unchanged and completes in the following cycle.
- R9: A divide by zero raises no trap and completes with the same busy timing as any divide. The values left in HI and LO are not specified.
- R10: Operation codes 6 and 7 have no effect on HI, LO or busy_o.
- R11: While reset is asserted, HI and LO are zero and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to launch the operation on op_i |
| op_i | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 load HI, 5 load LO) |
| a_i | input | WIDTH | First operand / dividend / load data |
| b_i | input | WIDTH | Second operand / divisor |
| busy_o | output | 1 | Divide in progress |
| hi_o | output | WIDTH | HI result register |
| lo_o | output | WIDTH | LO result register |

## Verification
The bench builds the unit with the default WIDTH of 32. At that width a 64-bit behavioural reference holds every product and signed quotient exactly, including the most-negative operand cases, and the divide window is 33 cycles long. Requests made partway through that window, divides by zero and the unused operation codes can therefore all be checked against the reference on every clock.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_SET_HI = 3'd4,
    OP_SET_LO = 3'd5
  } md_op_e;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_ITER = 2'd1,
    DV_FIX  = 2'd2
  } dv_state_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_signed,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2*WIDTH + 2;

  logic signed [WIDTH:0]  a_ext;
  logic signed [WIDTH:0]  b_ext;
  logic signed [PW-1:0]   full;

  always_comb begin
    a_ext = {is_signed & a[WIDTH-1], a};
    b_ext = {is_signed & b[WIDTH-1], b};
    full  = PW'(a_ext) * PW'(b_ext);
    prod  = full[2*WIDTH-1:0];
  end

  // a signed product of two nonzero operands carries the xor of their signs
  p_prod_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_signed && a != '0 && b != '0) |-> (prod[2*WIDTH-1] == (a[WIDTH-1] ^ b[WIDTH-1])));

  // unsigned product by one returns the operand with a zero upper half
  p_unit_mul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_signed && b == WIDTH'(1)) |-> (prod == {{WIDTH{1'b0}}, a}));

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  import muldiv_pkg::*;

  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  dv_state_e        state_q, state_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [WIDTH:0]   rem_q, rem_n;
  logic [WIDTH-1:0] quo_q, quo_n;
  logic [WIDTH-1:0] dvs_q, dvs_n;
  logic             negq_q, negq_n;
  logic             negr_q, negr_n;
  logic             en;

  logic [WIDTH:0]   rem_sh;
  logic [WIDTH:0]   trial;
  logic [WIDTH-1:0] mag_dd;
  logic [WIDTH-1:0] mag_dv;

  always_comb begin
    mag_dd = (is_signed && dividend[WIDTH-1]) ? (~dividend + 1'b1) : dividend;
    mag_dv = (is_signed && divisor[WIDTH-1])  ? (~divisor + 1'b1)  : divisor;
    rem_sh = {rem_q[WIDTH-1:0], quo_q[WIDTH-1]};
    trial  = rem_sh - {1'b0, dvs_q};
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    negq_n  = negq_q;
    negr_n  = negr_q;
    unique case (state_q)
      DV_IDLE: begin
        if (start) begin
          state_n = DV_ITER;
          cnt_n   = '0;
          rem_n   = '0;
          quo_n   = mag_dd;
          dvs_n   = mag_dv;
          negq_n  = is_signed & (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
          negr_n  = is_signed & dividend[WIDTH-1];
        end
      end
      DV_ITER: begin
        if (!trial[WIDTH]) begin
          rem_n = trial;
          quo_n = {quo_q[WIDTH-2:0], 1'b1};
        end else begin
          rem_n = rem_sh;
          quo_n = {quo_q[WIDTH-2:0], 1'b0};
        end
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == LAST) state_n = DV_FIX;
      end
      DV_FIX:  state_n = DV_IDLE;
      default: state_n = DV_IDLE;
    endcase
  end

  assign en = (state_q != DV_IDLE) | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
    end else if (en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rem_q   <= rem_n;
      quo_q   <= quo_n;
      dvs_q   <= dvs_n;
      negq_q  <= negq_n;
      negr_q  <= negr_n;
    end
  end

  always_comb begin
    busy_o = (state_q != DV_IDLE);
    done_o = (state_q == DV_FIX);
    quo_o  = negq_q ? (~quo_q + 1'b1) : quo_q;
    rem_o  = negr_q ? (~rem_q[WIDTH-1:0] + 1'b1) : rem_q[WIDTH-1:0];
  end

  // restoring step keeps the partial remainder below the divisor magnitude
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dvs_q != '0) |-> (rem_q[WIDTH] == 1'b0 && rem_q[WIDTH-1:0] < dvs_q));

  // the sign fix-up always follows the last iteration
  p_fix_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state_q == DV_ITER));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mul_we,
  input  logic [2*WIDTH-1:0] mul_prod,
  input  logic               div_we,
  input  logic [WIDTH-1:0]   div_quo,
  input  logic [WIDTH-1:0]   div_rem,
  input  logic               hi_we,
  input  logic               lo_we,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   hi_o,
  output logic [WIDTH-1:0]   lo_o
);
  logic [WIDTH-1:0] hi_q, hi_n;
  logic [WIDTH-1:0] lo_q, lo_n;
  logic             hi_en, lo_en;

  always_comb begin
    hi_n  = hi_q;
    lo_n  = lo_q;
    hi_en = mul_we | div_we | hi_we;
    lo_en = mul_we | div_we | lo_we;
    if (mul_we) begin
      hi_n = mul_prod[2*WIDTH-1:WIDTH];
      lo_n = mul_prod[WIDTH-1:0];
    end else if (div_we) begin
      hi_n = div_rem;
      lo_n = div_quo;
    end else begin
      if (hi_we) hi_n = wdata;
      if (lo_we) lo_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // at most one source may update the pair in any cycle
  p_one_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_we, div_we, hi_we, lo_we}));

  // a single-register load leaves its partner alone
  p_load_hi_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> ($stable(lo_o) && hi_o == $past(wdata)));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  import muldiv_pkg::*;

  localparam int RUNW = $clog2(WIDTH + 2) + 1;

  logic               accept;
  logic               is_mul, is_div, is_signed;
  logic               mul_we, div_start, hi_we, lo_we;
  logic [2*WIDTH-1:0] prod;
  logic               div_busy, div_done;
  logic [WIDTH-1:0]   div_quo, div_rem;

  always_comb begin
    accept    = start_i & ~div_busy;
    is_mul    = (op_i == OP_MUL_S) | (op_i == OP_MUL_U);
    is_div    = (op_i == OP_DIV_S) | (op_i == OP_DIV_U);
    is_signed = (op_i == OP_MUL_S) | (op_i == OP_DIV_S);
    mul_we    = accept & is_mul;
    div_start = accept & is_div;
    hi_we     = accept & (op_i == OP_SET_HI);
    lo_we     = accept & (op_i == OP_SET_LO);
  end

  muldiv_mul #(.WIDTH(WIDTH)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_signed (is_signed),
    .a         (a_i),
    .b         (b_i),
    .prod      (prod)
  );

  muldiv_div #(.WIDTH(WIDTH)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .is_signed (is_signed),
    .dividend  (a_i),
    .divisor   (b_i),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quo_o     (div_quo),
    .rem_o     (div_rem)
  );

  muldiv_hilo #(.WIDTH(WIDTH)) u_hilo (
    .clk      (clk),
    .rst_n    (rst_n),
    .mul_we   (mul_we),
    .mul_prod (prod),
    .div_we   (div_done),
    .div_quo  (div_quo),
    .div_rem  (div_rem),
    .hi_we    (hi_we),
    .lo_we    (lo_we),
    .wdata    (a_i),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );

  assign busy_o = div_busy;

  // run length of the busy window, kept for the latency check only
  logic [RUNW-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy_o) begin
      busy_run <= busy_run + 1'b1;
    end else begin
      busy_run <= '0;
    end
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == RUNW'(WIDTH + 1)));

  p_div_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i && (op_i == OP_DIV_S || op_i == OP_DIV_U)));

  p_hilo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($stable(hi_o) && $stable(lo_o)));

  p_unused_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i[2:1] == 2'b11 && !busy_o) |=> ($stable(hi_o) && $stable(lo_o) && !busy_o));

endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [2:0]   op_i;
  logic [W-1:0] a_i, b_i;
  logic         busy_o;
  logic [W-1:0] hi_o, lo_o;

  always #5 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // reference model state
  logic [W-1:0] m_hi, m_lo, p_q, p_r;
  bit           m_busy, hi_x, lo_x, p_x;
  int           m_cnt;
  string        hi_tag, lo_tag, busy_tag;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_div(bit sgn, logic [W-1:0] a, logic [W-1:0] b,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
    end else begin
      sa = longint'({32'b0, a});
      sb = longint'({32'b0, b});
    end
    q = W'(sa / sb);
    r = W'(sa % sb);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [63:0] pr;
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_busy = 0; m_cnt = 0;
      hi_x = 0; lo_x = 0; hi_tag = "R11"; lo_tag = "R11"; busy_tag = "R11";
    end else if (m_busy) begin
      if (start_i) begin hi_tag = "R7"; lo_tag = "R7"; end
      m_cnt++;
      if (m_cnt == W + 1) begin
        m_busy = 0;
        m_hi = p_r; m_lo = p_q; hi_x = p_x; lo_x = p_x;
      end
    end else if (start_i) begin
      case (op_i)
        3'd0: begin
          pr = 64'($signed({{32{a_i[31]}}, a_i}) * $signed({{32{b_i[31]}}, b_i}));
          m_hi = pr[63:32]; m_lo = pr[31:0]; hi_x = 0; lo_x = 0;
          hi_tag = "R1"; lo_tag = "R1";
        end
        3'd1: begin
          pr = {32'b0, a_i} * {32'b0, b_i};
          m_hi = pr[63:32]; m_lo = pr[31:0]; hi_x = 0; lo_x = 0;
          hi_tag = "R2"; lo_tag = "R2";
        end
        3'd2, 3'd3: begin
          m_busy = 1; m_cnt = 0;
          p_x = (b_i == '0);
          if (!p_x) ref_div(op_i == 3'd2, a_i, b_i, p_q, p_r);
          busy_tag = p_x ? "R9" : "R5";
          hi_tag = (op_i == 3'd2) ? "R3" : "R4";
          lo_tag = hi_tag;
        end
        3'd4: begin m_hi = a_i; hi_x = 0; hi_tag = "R8"; end
        3'd5: begin m_lo = a_i; lo_x = 0; lo_tag = "R8"; end
        default: begin hi_tag = "R10"; lo_tag = "R10"; end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy_tag, "busy", W'(busy_o), W'(m_busy));
      if (!hi_x) check(hi_tag, "hi", hi_o, m_hi);
      if (!lo_x) check(lo_tag, "lo", lo_o, m_lo);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic issue(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "hi at reset", hi_o, '0);
    check("R11", "lo at reset", lo_o, '0);
    check("R11", "busy at reset", W'(busy_o), '0);
    rst_n = 1'b1;

    // R2 worked example
    issue(3'd1, 32'd10, 32'd268435456);
    check("R2", "lo example", lo_o, 32'hA0000000);
    check("R2", "hi example", hi_o, 32'h0);
    // R1 signed multiply corners
    issue(3'd0, 32'hFFFFFFFF, 32'd5);
    issue(3'd0, 32'h80000000, 32'h80000000);
    issue(3'd0, 32'h7FFFFFFF, 32'h80000000);
    issue(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R8 direct loads
    issue(3'd4, 32'hDEADBEEF, 32'h0);
    issue(3'd5, 32'h12345678, 32'h0);
    check("R8", "hi load", hi_o, 32'hDEADBEEF);
    // R10 unused codes
    issue(3'd6, 32'h1, 32'h1);
    issue(3'd7, 32'h2, 32'h2);
    check("R10", "hi after code 7", hi_o, 32'hDEADBEEF);
    // R3 signed divide sign cases
    issue(3'd2, -32'sd7, 32'd2);              wait_idle();
    check("R3", "quotient -7/2", lo_o, 32'hFFFFFFFD);
    check("R3", "remainder -7/2", hi_o, 32'hFFFFFFFF);
    issue(3'd2, 32'd7, -32'sd2);              wait_idle();
    issue(3'd2, -32'sd7, -32'sd2);            wait_idle();
    issue(3'd2, 32'h80000000, 32'hFFFFFFFF);  wait_idle();
    // R4 unsigned divide
    issue(3'd3, 32'hFFFFFFFF, 32'd10);        wait_idle();
    check("R4", "udiv quotient", lo_o, 32'd429496729);
    check("R4", "udiv remainder", hi_o, 32'd5);
    issue(3'd3, 32'd3, 32'd7);                wait_idle();
    // R9 divide by zero, timing only
    issue(3'd3, 32'd99, 32'd0);               wait_idle();
    issue(3'd2, -32'sd99, 32'd0);             wait_idle();
    // R7 requests during a divide
    issue(3'd3, 32'd1000, 32'd7);
    issue(3'd0, 32'd3, 32'd3);
    issue(3'd4, 32'hAAAA5555, 32'd0);
    issue(3'd2, 32'd5, 32'd1);
    wait_idle();
    check("R7", "lo after ignored requests", lo_o, 32'd142);
    // R5 back-to-back divide immediately after finish
    issue(3'd2, 32'd100, -32'sd9);
    wait_idle();
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      issue(op, $urandom, (i % 5 == 0) ? 32'($urandom_range(1, 9)) : $urandom);
      if ($urandom_range(0, 1) == 1) wait_idle();
    end
    wait_idle();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule